// File: doc/BRIEF.md
# Synchronous Receive Sync Hunt Detector

This block sits on the serial receive path of a synchronous link and runs on the receive clock, taking one data bit on every rising edge. While it hunts, it searches the incoming bit stream for a synchronization pattern. The pattern can be a single programmable 8-bit character, a programmable 16-bit pair, or the fixed 8-bit flag 0x7E. Once a pattern is found, the block frames 8-bit characters from the next bit onward. In a fourth sync mode the framing point comes from an external active-low sync input instead of from a match. A fifth, asynchronous mode only turns that input into a status bit.

The sync indication is not latched. In the three pattern modes, the active-low sync output is low only for the receive-clock cycle that follows a recognized pattern. It fires on every recognition, including matches that straddle a character boundary after framing has been set. In the external mode, framing is back-dated. The external input goes through a synchronizer, so by the time its falling edge is seen several bits have already arrived. Those bits are kept in the detection window and loaded into the character, so that the first character bit is the one sampled on the edge just before the input went low.

Top module: `sync_hunt_rx`

## Requirements
- R1: After reset `hunt` is 1, `sync_out_n` is 1, and `char_start` and `char_valid` are 0.
- R2: Mode encoding on `mode`: 0 asynchronous, 1 monosync, 2 bisync, 3 flag, 4 external; 5 to 7 behave as 0. In monosync, `sync_out_n` is 0 during the cycle after the edge that sampled the last bit of a match, and 1 again in the following cycle unless the next bit completes another match. A match means the last 8 bits equal `pat_lo`, with the earliest bit compared to bit 0.
- R3: In bisync, a match needs the last 16 bits to equal {`pat_hi`,`pat_lo`}, with `pat_lo` received first and LSB first. The 8 bits of `pat_lo` alone do not match.
- R4: In flag mode, a match is the last 8 bits equal to 0x7E, which arrives as 0,1,1,1,1,1,1,0.
- R5: Matches drive `sync_out_n` low whether or not the block is hunting and wherever they fall relative to character boundaries. Outside hunt, a match does not move the framing.
- R6: No match is reported until at least as many bits as the pattern width have been sampled since reset.
- R7: While hunting, a match clears `hunt` at the next edge. The bit sampled at that edge becomes bit 0 of the first character, and `char_start` is 1 for the cycle after it.
- R8: Characters are 8 bits, LSB first. `char_valid` is 1 for one cycle after the edge that samples the 8th bit, with `char_data` holding the character. `char_start` is 1 after the first bit of every character.
- R9: `hunt_enter` sets `hunt` at the next edge, ahead of any match. It throws away a partly built character and starts none.
- R10: In external mode, `sync_in_n` passes through a two-stage synchronizer. On its falling edge while hunting, framing starts so that the first character bit is the bit sampled on the edge just before `sync_in_n` was first sampled low. `char_start` is 1 after the fourth bit, counted from that first one.
- R11: In asynchronous mode, `async_stat` equals the inverse of `sync_in_n` two edges later. `sync_out_n` stays 1, and `hunt`, `char_start` and `char_valid` do not change.
- R12: `sync_oe` is 1 in monosync, bisync and flag modes and 0 in the others, where `sync_out_n` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, one bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Serial receive data |
| mode | input | 3 | Sync mode select |
| pat_lo | input | 8 | Monosync pattern, first byte of the bisync pair |
| pat_hi | input | 8 | Second byte of the bisync pair |
| hunt_enter | input | 1 | Force return to hunt |
| sync_in_n | input | 1 | External active-low sync input |
| sync_out_n | output | 1 | Active-low unlatched pattern recognized |
| sync_oe | output | 1 | Sync pin acts as output in this mode |
| hunt | output | 1 | Hunt status |
| char_start | output | 1 | First bit of a character was just taken |
| char_valid | output | 1 | Character complete |
| char_data | output | 8 | Assembled character |
| async_stat | output | 1 | Synchronized sync input status |

## Verification
The bench builds the block with its default parameters: 8-bit characters, a 16-bit window, a two-stage synchronizer and the 0x7E flag. With these, the back-dated external framing loads exactly three history bits plus the current bit, so the test can name every bit of the first character. The 16-bit window lets one stream show a lone first byte failing to match in bisync. Because the fill guard of 8 is reached just after reset, a zero pattern tests the guard directly. Sliding-window matches are placed three bits off the character boundary, so any wrong reframing would shift the next completed character.

// File: rtl/sync_hunt_pkg.sv
package sync_hunt_pkg;

    typedef enum logic [2:0] {
        MD_ASYNC  = 3'd0,
        MD_MONO   = 3'd1,
        MD_BISYNC = 3'd2,
        MD_FLAG   = 3'd3,
        MD_EXT    = 3'd4
    } rx_mode_e;

endpackage

// File: rtl/sync_hunt_window.sv
module sync_hunt_window #(
    parameter int CHAR_W = 8,
    parameter int WIN_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_bit,
    output logic [WIN_W-1:0] win,
    output logic             full_char,
    output logic             full_win
);
    localparam int FILL_W = $clog2(WIN_W + 1);

    typedef struct packed {
        logic [WIN_W-1:0]  bits;
        logic [FILL_W-1:0] fill;
    } win_state_t;

    win_state_t st_d, st_q;

    // newest bit enters at the top, so the oldest bit sits at index 0
    always_comb begin
        st_d      = st_q;
        st_d.bits = {rx_bit, st_q.bits[WIN_W-1:1]};
        if (st_q.fill != FILL_W'(WIN_W)) begin
            st_d.fill = st_q.fill + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign win       = st_q.bits;
    assign full_char = (st_q.fill >= FILL_W'(CHAR_W));
    assign full_win  = (st_q.fill == FILL_W'(WIN_W));

    AST_WINDOW_TAKES_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (win[WIN_W-1] == $past(rx_bit))) else $error("window shift"); // R2

endmodule

// File: rtl/sync_hunt_match.sv
module sync_hunt_match
    import sync_hunt_pkg::*;
#(
    parameter int              CHAR_W   = 8,
    parameter int              WIN_W    = 16,
    parameter logic [CHAR_W-1:0] FLAG_PAT = 8'h7E
) (
    input  logic [2:0]        mode,
    input  logic [WIN_W-1:0]  win,
    input  logic              full_char,
    input  logic              full_win,
    input  logic [CHAR_W-1:0] pat_lo,
    input  logic [CHAR_W-1:0] pat_hi,
    output logic              match
);
    logic [CHAR_W-1:0] recent;
    logic              hit_mono;
    logic              hit_pair;
    logic              hit_flag;

    assign recent = win[WIN_W-1 -: CHAR_W];

    always_comb begin
        hit_mono = full_char && (recent == pat_lo);
        hit_pair = full_win  && (win == {pat_hi, pat_lo});
        hit_flag = full_char && (recent == FLAG_PAT);
        unique case (mode)
            MD_MONO:   match = hit_mono;
            MD_BISYNC: match = hit_pair;
            MD_FLAG:   match = hit_flag;
            default:   match = 1'b0;
        endcase
    end

endmodule

// File: rtl/sync_hunt_extsync.sv
module sync_hunt_extsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in_n,
    output logic sync_act,
    output logic fall_seen
);
    // chain[0] is the first flop; chain[STAGES] is one extra stage for edge detection
    typedef struct packed {
        logic [STAGES:0] chain;
    } sy_state_t;

    sy_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-1:0], sync_in_n};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_act  = ~st_q.chain[STAGES-1];
    assign fall_seen = st_q.chain[STAGES] & ~st_q.chain[STAGES-1];

    AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall_seen |=> !fall_seen) else $error("fall pulse"); // R10

endmodule

// File: rtl/sync_hunt_framer.sv
module sync_hunt_framer #(
    parameter int CHAR_W = 8,
    parameter int BACK   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_bit,
    input  logic [BACK-1:0]   back_bits,
    input  logic              match_go,
    input  logic              ext_go,
    input  logic              hunt_enter,
    output logic              hunt,
    output logic              char_start,
    output logic              char_valid,
    output logic [CHAR_W-1:0] char_data
);
    localparam int CNT_W = $clog2(CHAR_W);
    localparam int PAD_W = CHAR_W - 1 - BACK;

    typedef struct packed {
        logic              hunt;
        logic [CNT_W-1:0]  cnt;
        logic [CHAR_W-1:0] acc;
        logic [CHAR_W-1:0] out;
        logic              start;
        logic              valid;
    } frm_state_t;

    frm_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        st_d.valid = 1'b0;
        if (hunt_enter) begin
            st_d.hunt = 1'b1;
            st_d.cnt  = '0;
        end else if (st_q.hunt) begin
            if (ext_go) begin
                // back-dated start: history bits plus the current bit
                st_d.hunt  = 1'b0;
                st_d.acc   = {rx_bit, back_bits, {PAD_W{1'b0}}};
                st_d.cnt   = CNT_W'(BACK + 1);
                st_d.start = 1'b1;
            end else if (match_go) begin
                st_d.hunt  = 1'b0;
                st_d.acc   = {rx_bit, {(CHAR_W-1){1'b0}}};
                st_d.cnt   = CNT_W'(1);
                st_d.start = 1'b1;
            end
        end else begin
            st_d.acc   = {rx_bit, st_q.acc[CHAR_W-1:1]};
            st_d.start = (st_q.cnt == '0);
            if (st_q.cnt == CNT_W'(CHAR_W - 1)) begin
                st_d.valid = 1'b1;
                st_d.out   = {rx_bit, st_q.acc[CHAR_W-1:1]};
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.hunt <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign hunt       = st_q.hunt;
    assign char_start = st_q.start;
    assign char_valid = st_q.valid;
    assign char_data  = st_q.out;

    AST_HUNT_ENTER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hunt_enter |=> (hunt && !char_start && !char_valid)) else $error("hunt enter"); // R9
    AST_MATCH_FRAMES: assert property (@(posedge clk) disable iff (!rst_n)
        (hunt && match_go && !hunt_enter) |=> (!hunt && char_start)) else $error("match frame"); // R7
    AST_EXT_FRAMES: assert property (@(posedge clk) disable iff (!rst_n)
        (hunt && ext_go && !hunt_enter) |=> (!hunt && char_start)) else $error("ext frame"); // R10
    AST_VALID_OUT_OF_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |-> $past(!hunt)) else $error("valid in hunt"); // R8

endmodule

// File: rtl/sync_hunt_rx.sv
module sync_hunt_rx
    import sync_hunt_pkg::*;
#(
    parameter int                CHAR_W      = 8,
    parameter int                SYNC_STAGES = 2,
    parameter logic [CHAR_W-1:0] FLAG_PAT    = 8'h7E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_bit,
    input  logic [2:0]        mode,
    input  logic [CHAR_W-1:0] pat_lo,
    input  logic [CHAR_W-1:0] pat_hi,
    input  logic              hunt_enter,
    input  logic              sync_in_n,
    output logic              sync_out_n,
    output logic              sync_oe,
    output logic              hunt,
    output logic              char_start,
    output logic              char_valid,
    output logic [CHAR_W-1:0] char_data,
    output logic              async_stat
);
    localparam int WIN_W = 2 * CHAR_W;
    localparam int BACK  = SYNC_STAGES + 1;

    logic [WIN_W-1:0] win;
    logic             full_char;
    logic             full_win;
    logic             match;
    logic             sync_act;
    logic             fall_seen;
    logic             pattern_mode;
    logic             match_go;
    logic             ext_go;

    assign pattern_mode = (mode == MD_MONO) || (mode == MD_BISYNC) || (mode == MD_FLAG);
    assign match_go     = pattern_mode && match;
    assign ext_go       = (mode == MD_EXT) && fall_seen;

    sync_hunt_window #(.CHAR_W(CHAR_W), .WIN_W(WIN_W)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_bit    (rx_bit),
        .win       (win),
        .full_char (full_char),
        .full_win  (full_win)
    );

    sync_hunt_match #(.CHAR_W(CHAR_W), .WIN_W(WIN_W), .FLAG_PAT(FLAG_PAT)) u_match (
        .mode      (mode),
        .win       (win),
        .full_char (full_char),
        .full_win  (full_win),
        .pat_lo    (pat_lo),
        .pat_hi    (pat_hi),
        .match     (match)
    );

    sync_hunt_extsync #(.STAGES(SYNC_STAGES)) u_extsync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_in_n (sync_in_n),
        .sync_act  (sync_act),
        .fall_seen (fall_seen)
    );

    sync_hunt_framer #(.CHAR_W(CHAR_W), .BACK(BACK)) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_bit     (rx_bit),
        .back_bits  (win[WIN_W-1 -: BACK]),
        .match_go   (match_go),
        .ext_go     (ext_go),
        .hunt_enter (hunt_enter),
        .hunt       (hunt),
        .char_start (char_start),
        .char_valid (char_valid),
        .char_data  (char_data)
    );

    assign sync_out_n = ~match_go;
    assign sync_oe    = pattern_mode;
    assign async_stat = sync_act;

    AST_QUIET_IN_ASYNC: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MD_ASYNC) && hunt && !hunt_enter) |=> (hunt && !char_start)) else $error("async"); // R11
    AST_GUARD_BEFORE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        !full_char |-> sync_out_n) else $error("fill guard"); // R6

endmodule

// File: tb/sync_hunt_rx_bench.sv
module sync_hunt_rx_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_bit;
    logic [2:0] mode;
    logic [7:0] pat_lo, pat_hi;
    logic       hunt_enter, sync_in_n;
    logic       sync_out_n, sync_oe, hunt, char_start, char_valid, async_stat;
    logic [7:0] char_data;
    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    sync_hunt_rx u_sync_hunt_rx (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .mode(mode),
        .pat_lo(pat_lo), .pat_hi(pat_hi), .hunt_enter(hunt_enter),
        .sync_in_n(sync_in_n), .sync_out_n(sync_out_n), .sync_oe(sync_oe),
        .hunt(hunt), .char_start(char_start), .char_valid(char_valid),
        .char_data(char_data), .async_stat(async_stat)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        rx_bit = b;
        @(posedge clk);
        #2;
    endtask

    task automatic hunt_pulse();
        hunt_enter = 1'b1;
        send_bit(1'b1);
        hunt_enter = 1'b0;
        chk("R9 hunt after hunt_enter", hunt, 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; rx_bit = 1'b0; mode = 3'd1; pat_lo = 8'h00; pat_hi = 8'h00;
        hunt_enter = 1'b0; sync_in_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 hunt", hunt, 1);
        chk("R1 sync_out_n", sync_out_n, 1);
        chk("R1 char_start", char_start, 0);
        chk("R1 char_valid", char_valid, 0);
    endtask

    task automatic t_fill();
        for (int i = 0; i < 6; i++) begin
            send_bit(1'b0);
            chk("R6 no match before fill", sync_out_n, 1);
        end
        send_bit(1'b0);
        chk("R6 match at fill", sync_out_n, 0);
    endtask

    task automatic send_char_chk(input logic [7:0] c);
        for (int i = 0; i < 8; i++) begin
            send_bit(c[i]);
            if (i == 0) chk("R8 char_start on first bit", char_start, 1);
            else        chk("R8 char_start mid char", char_start, 0);
            if (i == 7) begin
                chk("R8 char_valid", char_valid, 1);
                chk("R8 char_data", char_data, c);
            end else begin
                chk("R8 no early valid", char_valid, 0);
            end
        end
    endtask

    task automatic t_mono();
        pat_lo = 8'hB4;
        hunt_pulse();
        repeat (3) send_bit(1'b1);
        for (int i = 0; i < 8; i++) begin
            send_bit(pat_lo[i]);
            if (i < 7) chk("R2 no partial match", sync_out_n, 1);
        end
        chk("R2 monosync match", sync_out_n, 0);
        chk("R7 still hunting at match", hunt, 1);
        chk("R12 sync_oe monosync", sync_oe, 1);
        send_bit(1'b0);
        chk("R2 unlatched", sync_out_n, 1);
        chk("R7 hunt cleared", hunt, 0);
        chk("R7 char_start first bit", char_start, 1);
        // first bit 0 already sent for 0x3C (bit0 = 0)
        for (int i = 1; i < 8; i++) send_bit(logic'(8'h3C >> i));
        chk("R7 first char valid", char_valid, 1);
        chk("R7 first char data", char_data, 8'h3C);
        send_char_chk(8'hA5);
    endtask

    task automatic t_slide();
        logic [15:0] s;
        s = {4'b0000, 1'b1, 8'hB4, 3'b111};
        for (int i = 0; i < 16; i++) begin
            send_bit(s[i]);
            if (i == 7) begin
                chk("R5 char before slide", char_valid, 1);
                chk("R5 char data before slide", char_data, 8'hA7);
            end
            if (i == 10) begin
                chk("R5 off-boundary match", sync_out_n, 0);
                chk("R5 no hunt change", hunt, 0);
            end
            if (i == 11) chk("R2 released next cycle", sync_out_n, 1);
            if (i == 14) chk("R5 no reframed valid", char_valid, 0);
            if (i == 15) begin
                chk("R5 framing kept", char_valid, 1);
                chk("R5 framing kept data", char_data, 8'h0D);
            end
        end
    endtask

    task automatic t_bisync();
        mode = 3'd2; pat_lo = 8'hB4; pat_hi = 8'h96;
        hunt_pulse();
        for (int i = 0; i < 8; i++) send_bit(pat_lo[i]);
        chk("R3 first byte alone no match", sync_out_n, 1);
        for (int i = 0; i < 8; i++) send_bit(pat_hi[i]);
        chk("R3 bisync match", sync_out_n, 0);
        chk("R3 hunt at match", hunt, 1);
        send_bit(1'b0);
        chk("R3 hunt cleared", hunt, 0);
        chk("R3 char_start", char_start, 1);
    endtask

    task automatic t_flag();
        logic [7:0] f;
        f = 8'h7E;
        mode = 3'd3;
        hunt_pulse();
        for (int i = 0; i < 8; i++) begin
            send_bit(f[i]);
            if (i == 6) chk("R4 no early flag", sync_out_n, 1);
        end
        chk("R4 flag match", sync_out_n, 0);
        send_bit(1'b1);
        chk("R4 hunt cleared", hunt, 0);
    endtask

    task automatic t_hunt_enter();
        int seen;
        seen = 0;
        repeat (3) send_bit(1'b1);
        hunt_enter = 1'b1;
        send_bit(1'b1);
        hunt_enter = 1'b0;
        chk("R9 hunt set", hunt, 1);
        chk("R9 no start", char_start, 0);
        for (int i = 0; i < 8; i++) begin
            send_bit(1'b1);
            if (char_valid) seen++;
        end
        chk("R9 partial char dropped", seen, 0);
    endtask

    task automatic t_ext();
        logic [7:0] d;
        d = 8'h5A;
        mode = 3'd4;
        sync_in_n = 1'b1;
        send_bit(1'b1);
        send_bit(1'b1);
        send_bit(d[0]);
        sync_in_n = 1'b0;
        send_bit(d[1]);
        chk("R10 no start yet", char_start, 0);
        send_bit(d[2]);
        chk("R10 still hunting", hunt, 1);
        send_bit(d[3]);
        chk("R10 start after fourth bit", char_start, 1);
        chk("R10 hunt cleared", hunt, 0);
        chk("R12 sync_out_n idle ext", sync_out_n, 1);
        chk("R12 sync_oe ext", sync_oe, 0);
        for (int i = 4; i < 8; i++) send_bit(d[i]);
        chk("R10 back-dated valid", char_valid, 1);
        chk("R10 back-dated data", char_data, 8'h5A);
        sync_in_n = 1'b1;
    endtask

    task automatic t_async();
        mode = 3'd0; pat_lo = 8'hB4;
        hunt_pulse();
        send_bit(1'b1);
        chk("R11 status idle", async_stat, 0);
        sync_in_n = 1'b0;
        send_bit(1'b1);
        chk("R11 status after one edge", async_stat, 0);
        send_bit(1'b1);
        chk("R11 status after two edges", async_stat, 1);
        for (int i = 0; i < 8; i++) send_bit(pat_lo[i]);
        chk("R11 no sync out", sync_out_n, 1);
        send_bit(1'b1);
        chk("R11 hunt kept", hunt, 1);
        chk("R11 no start", char_start, 0);
        chk("R11 no valid", char_valid, 0);
        sync_in_n = 1'b1;
        send_bit(1'b1);
        send_bit(1'b1);
        chk("R11 status released", async_stat, 0);
    endtask

    initial begin
        t_reset();
        t_fill();
        t_mono();
        t_slide();
        t_bisync();
        t_flag();
        t_hunt_enter();
        t_ext();
        t_async();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule